// File: doc/BRIEF.md
# Dual-channel capture/compare timer

A 16-bit up-counter shared by two event channels, all reached through a byte-wide register bus. A control byte starts and stops the counter. It also holds sticky event flags: one for counter wrap-around and one per channel. Each channel has a mode byte and a 16-bit value register.

A channel can take a snapshot of the counter on chosen edges of its input pin. It can also compare the counter against its value register. A match can raise the channel flag, invert the channel output, or both. In PWM mode, the channel output instead follows a duty cycle set by the low byte of the value register.

Flags stay set until software writes a zero to them. The wrap flag, and each channel flag whose interrupt enable is set, feed a single interrupt line.

Top module: `capcmp_timer`

## Requirements
- R1: After reset every register reads 0x00, both channel outputs are 0 and the interrupt line is 0.
- R2: Bit 6 of the control byte (address 0x0) is the run bit. While it is 1 the counter (low byte at 0x1, high byte at 0x2) rises by one each clock. While it is 0 the counter holds its value.
- R3: Bit 7 of the control byte is the wrap flag. It is set in the cycle after a running counter steps from 0xFFFF to 0x0000. Writing 0 to it clears it. Writing 1 to it leaves it unchanged.
- R4: In a channel mode byte, bit 6 enables compare and bit 3 enables flag-on-match. With both set, the channel flag (control bit 0 for channel 0, bit 1 for channel 1) is set when the running counter equals the channel value register. Writing 0 to a flag bit clears it; writing 1 to it has no effect.
- R5: With mode bit 6 and mode bit 2 set, and PWM off, the channel output inverts on every match.
- R6: Mode bit 5 selects capture on rising input edges and bit 4 on falling edges; with both set, either edge captures. The input passes through a two-stage synchronizer. On a capture, the current counter is copied into the value register and the channel flag is set.
- R7: With mode bit 1 set, the channel output is updated every clock. It becomes 1 while the counter low byte is below the value register low byte, and 0 otherwise. PWM takes priority over toggling.
- R8: The interrupt line is 1 whenever the wrap flag is set, or a channel flag is set while bit 0 of that channel's mode byte is 1.
- R9: A hardware flag set and a software clear of the same flag in one cycle leave the flag set. A capture in the same cycle as a bus write to that value register stores the captured counter.
- R10: Channel 0 registers sit at 0x4 (mode), 0x5 (value low) and 0x6 (value high); channel 1 at 0x8, 0x9 and 0xA. Each reads back what was last written or captured. Unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cap_in | input | NCH | Channel capture inputs, asynchronous |
| cmp_out | output | NCH | Channel toggle / PWM outputs |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is a hardware flag set (match or capture) and a software clear of that flag. The second is a capture and a bus write to the same value register. Both are provoked by sustained bus traffic: control-byte clears, or value-register writes, are issued every cycle across a window that contains the compare match or the synchronized input edge. The bench does not aim for one exact cycle. A behavioural model, updated on each edge, settles each collision: the set wins and the captured value wins. Flags, value registers and outputs are compared against that model on every clock.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  // Channel mode byte, bit 7 down to bit 0
  typedef struct packed {
    logic spare;     // bit 7, storage only
    logic cmp_en;    // bit 6
    logic cap_rise;  // bit 5
    logic cap_fall;  // bit 4
    logic mat_flag;  // bit 3
    logic tog;       // bit 2
    logic pwm;       // bit 1
    logic irq_en;    // bit 0
  } mode_t;

  localparam int CTRL_ADDR  = 0;
  localparam int CNTL_ADDR  = 1;
  localparam int CNTH_ADDR  = 2;
  localparam int CH_STRIDE  = 4;
  localparam int CTRL_OVF   = 7;
  localparam int CTRL_RUN   = 6;
endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, prev_q;
  logic s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = pin;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/capcmp_counter.sv
module capcmp_counter
  import capcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             run_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_d;
  logic             run_d, ovf_d, wrap;

  always_comb begin
    wrap  = run & (cnt == {CNT_W{1'b1}});
    cnt_d = cnt;
    if (run) cnt_d = cnt + CNT_W'(1);
    run_d = ctrl_we ? run_wdata : run;
    ovf_d = wrap | (ovf & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_d;
      run <= run_d;
      ovf <= ovf_d;
    end
  end
endmodule

// File: rtl/capcmp_chan.sv
module capcmp_chan
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              run,
  input  logic              pin,
  input  logic              mode_we,
  input  logic              vlo_we,
  input  logic              vhi_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              flag_clr,
  output mode_t             mode,
  output logic [CNT_W-1:0]  val,
  output logic              flag,
  output logic              set_ev,
  output logic              out_pin
);
  logic             rise, fall, cap, match;
  mode_t            mode_d;
  logic [CNT_W-1:0] val_d;
  logic             flag_d, out_d;

  capcmp_edge edge_i (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .rise (rise),
    .fall (fall)
  );

  always_comb begin
    cap    = (mode.cap_rise & rise) | (mode.cap_fall & fall);
    match  = mode.cmp_en & run & (cnt == val);
    set_ev = cap | (match & mode.mat_flag);

    mode_d = mode_we ? mode_t'(wdata) : mode;

    val_d = val;
    if (vlo_we) val_d[BYTE_W-1:0]     = wdata;
    if (vhi_we) val_d[CNT_W-1:BYTE_W] = wdata;
    if (cap)    val_d                 = cnt;

    flag_d = set_ev | (flag & ~flag_clr);

    if (mode.pwm)               out_d = cnt[BYTE_W-1:0] < val[BYTE_W-1:0];
    else if (mode.tog && match) out_d = ~out_pin;
    else                        out_d = out_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      val     <= '0;
      flag    <= 1'b0;
      out_pin <= 1'b0;
    end else begin
      mode    <= mode_d;
      val     <= val_d;
      flag    <= flag_d;
      out_pin <= out_d;
    end
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    cmp_out,
  output logic              irq
);
  logic             rst_a_q, rst_b_q, rst_int_n;
  logic             ctrl_we;
  logic [CNT_W-1:0] cnt;
  logic             run, ovf;
  logic [NCH-1:0]   flag, set_ev, ien;
  mode_t            mode [NCH];
  logic [CNT_W-1:0] val  [NCH];

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign rst_int_n = rst_b_q;

  assign ctrl_we = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));

  capcmp_counter cnt_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctrl_we  (ctrl_we),
    .run_wdata(bus_wdata[CTRL_RUN]),
    .ovf_clr  (ctrl_we & ~bus_wdata[CTRL_OVF]),
    .cnt      (cnt),
    .run      (run),
    .ovf      (ovf)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int BASE = CH_STRIDE * (n + 1);
    capcmp_chan ch_i (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .cnt     (cnt),
      .run     (run),
      .pin     (cap_in[n]),
      .mode_we (bus_we && (bus_addr == ADDR_W'(BASE))),
      .vlo_we  (bus_we && (bus_addr == ADDR_W'(BASE + 1))),
      .vhi_we  (bus_we && (bus_addr == ADDR_W'(BASE + 2))),
      .wdata   (bus_wdata),
      .flag_clr(ctrl_we & ~bus_wdata[n]),
      .mode    (mode[n]),
      .val     (val[n]),
      .flag    (flag[n]),
      .set_ev  (set_ev[n]),
      .out_pin (cmp_out[n])
    );
    assign ien[n] = mode[n].irq_en;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[CTRL_OVF] = ovf;
      bus_rdata[CTRL_RUN] = run;
      bus_rdata[NCH-1:0]  = flag;
    end
    if (bus_addr == ADDR_W'(CNTL_ADDR)) bus_rdata = cnt[7:0];
    if (bus_addr == ADDR_W'(CNTH_ADDR)) bus_rdata = cnt[15:8];
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(CH_STRIDE * (n + 1)))     bus_rdata = mode[n];
      if (bus_addr == ADDR_W'(CH_STRIDE * (n + 1) + 1)) bus_rdata = val[n][7:0];
      if (bus_addr == ADDR_W'(CH_STRIDE * (n + 1) + 2)) bus_rdata = val[n][15:8];
    end
  end

  assign irq = ovf | (|(flag & ien));
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [15:0]    cnt,
  input logic           run,
  input logic           ovf,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] set_ev,
  input logic           irq
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == $past(cnt));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == 16'($past(cnt) + 16'd1));

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == 16'hFFFF) |=> ovf);

  // R8
  irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> irq);

  for (genvar n = 0; n < NCH; n++) begin : g_f
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[n] |=> flag[n]);
  end
endmodule

bind capcmp_timer capcmp_timer_chk #(.NCH(NCH)) chk_i (
  .clk   (clk),
  .rst_n (rst_int_n),
  .cnt   (cnt),
  .run   (run),
  .ovf   (ovf),
  .flag  (flag),
  .set_ev(set_ev),
  .irq   (irq)
);

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic [1:0] pin = '0;
  logic [1:0] outp;
  logic       irq;

  always #4 clk = ~clk;  // 125 MHz

  capcmp_timer #(.NCH(2), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rd), .cap_in(pin), .cmp_out(outp), .irq(irq)
  );

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0, done = 1'b0;

  // reference model
  logic [15:0] m_cnt, m_val [2];
  logic [7:0]  m_mode [2];
  logic        m_run, m_ovf;
  logic        m_flag [2], m_out [2], m_s1 [2], m_s2 [2], m_pv [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_ovf = 0;
      for (int i = 0; i < 2; i++) begin
        m_val[i] = 0; m_mode[i] = 0; m_flag[i] = 0; m_out[i] = 0;
        m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0;
      end
    end else begin
      bit          cw;
      logic [15:0] nval [2];
      logic        nflag [2], nout [2];
      cw = we && addr == 0;
      for (int i = 0; i < 2; i++) begin
        bit rise, fall, cap, match;
        int base;
        base  = 4 * (i + 1);
        rise  = m_s2[i] && !m_pv[i];
        fall  = !m_s2[i] && m_pv[i];
        cap   = (m_mode[i][5] && rise) || (m_mode[i][4] && fall);
        match = m_mode[i][6] && m_run && m_cnt == m_val[i];
        nval[i] = m_val[i];
        if (we && addr == base + 1) nval[i][7:0]  = wd;
        if (we && addr == base + 2) nval[i][15:8] = wd;
        if (cap) nval[i] = m_cnt;
        nflag[i] = m_flag[i];
        if (cw && !wd[i]) nflag[i] = 0;
        if (cap || (match && m_mode[i][3])) nflag[i] = 1;
        nout[i] = m_out[i];
        if (m_mode[i][1]) nout[i] = m_cnt[7:0] < m_val[i][7:0];
        else if (m_mode[i][2] && match) nout[i] = !m_out[i];
      end
      for (int i = 0; i < 2; i++) begin
        m_val[i] = nval[i]; m_flag[i] = nflag[i]; m_out[i] = nout[i];
        if (we && addr == 4 * (i + 1)) m_mode[i] = wd;
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin[i];
      end
      if (cw && !wd[7]) m_ovf = 0;
      if (m_run && m_cnt == 16'hFFFF) m_ovf = 1;
      if (m_run) m_cnt = m_cnt + 16'd1;
      if (cw) m_run = wd[6];
    end
  end

  function automatic logic [7:0] m_read(logic [3:0] a);
    case (a)
      4'd0:  return {m_ovf, m_run, 4'b0, m_flag[1], m_flag[0]};
      4'd1:  return m_cnt[7:0];
      4'd2:  return m_cnt[15:8];
      4'd4:  return m_mode[0];
      4'd5:  return m_val[0][7:0];
      4'd6:  return m_val[0][15:8];
      4'd8:  return m_mode[1];
      4'd9:  return m_val[1][7:0];
      4'd10: return m_val[1][15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %02h expected %02h",
               cur_req, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      chk("bus_rdata", rd, m_read(addr));
      chk("cmp_out", {6'b0, outp}, {6'b0, m_out[1], m_out[0]});
      chk("irq", {7'b0, irq},
          {7'b0, m_ovf | (m_flag[0] & m_mode[0][0]) | (m_flag[1] & m_mode[1][0])});
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 150000", cyc);
      report();
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic look(logic [3:0] a, int n);
    @(negedge clk);
    addr = a;
    idle(n);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    cmp_on = 1'b1;

    cur_req = "R1";  // every register zero after reset
    for (int a = 0; a < 16; a++) look(4'(a), 1);

    cur_req = "R10";  // value registers read back
    wr(4'd5, 8'h34); wr(4'd6, 8'h12); wr(4'd9, 8'hCD); wr(4'd10, 8'hAB);
    wr(4'd4, 8'h80); wr(4'd8, 8'h80);
    for (int a = 0; a < 16; a++) look(4'(a), 1);

    cur_req = "R2";  // counting only while running
    look(4'd1, 5);
    wr(4'd0, 8'h40); look(4'd1, 20);
    wr(4'd0, 8'h00); look(4'd1, 6);
    look(4'd2, 2);

    cur_req = "R4";  // match sets flag 0
    wr(4'd5, 8'h40); wr(4'd6, 8'h00); wr(4'd4, 8'h49);
    wr(4'd0, 8'h40); look(4'd0, 60);
    cur_req = "R8";
    look(4'd0, 3);
    cur_req = "R4";
    wr(4'd0, 8'h42); look(4'd0, 4);

    cur_req = "R5";  // toggle channel 1
    wr(4'd9, 8'h80); wr(4'd10, 8'h00); wr(4'd8, 8'h44);
    look(4'd0, 300);

    cur_req = "R7";  // PWM on channel 0, toggle priority
    wr(4'd5, 8'h30); wr(4'd4, 8'h06);
    look(4'd1, 600);

    cur_req = "R6";  // capture edges on channel 1
    wr(4'd8, 8'h21);
    pin[1] = 1'b1; look(4'd9, 8);
    pin[1] = 1'b0; look(4'd10, 8);
    wr(4'd0, 8'h41);
    wr(4'd8, 8'h11);
    pin[1] = 1'b1; look(4'd9, 8);
    pin[1] = 1'b0; look(4'd9, 8);
    wr(4'd8, 8'h31);
    pin[1] = 1'b1; look(4'd0, 8);
    pin[1] = 1'b0; look(4'd9, 8);

    cur_req = "R9";  // clear storm across a match
    wr(4'd4, 8'h49);
    wr(4'd5, m_cnt[7:0] + 8'd8); wr(4'd6, m_cnt[15:8]);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); addr = 4'd0; wd = 8'h42; we = 1'b1;
    end
    @(negedge clk); we = 1'b0;
    look(4'd0, 3);
    // bus writes to value register across a capture
    wr(4'd8, 8'h30);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); addr = 4'd9; wd = 8'(i); we = 1'b1;
      if (i == 2) pin[1] = 1'b1;
    end
    @(negedge clk); we = 1'b0;
    look(4'd9, 3); look(4'd10, 2);

    cur_req = "R3";  // wrap flag: writing 1 does not set, wrap sets, 0 clears
    wr(4'd4, 8'h00); wr(4'd8, 8'h00);
    wr(4'd0, 8'hC3); look(4'd0, 5);
    look(4'd0, 65600);
    cur_req = "R8";
    look(4'd0, 3);
    cur_req = "R3";
    wr(4'd0, 8'h43); look(4'd0, 4);

    done = 1'b1;
    cmp_on = 1'b0;
    report();
    $finish;
  end
endmodule